// File: doc/BRIEF.md
# Quad-Channel Double-Buffered Serial Register Interface

This block is the digital front end of a four-channel 16-bit converter. A host shifts 24-bit frames into it over a serial port with an active-low select, a serial clock and a data line. Each frame carries an 8-bit command and then a 16-bit value. Every channel has two registers. The first is a staging (input) register. The second is a live (output) register that drives the converter and appears on a port of the block.

Three paths move staged values to the live registers:
- A hardware load pin, active low, copies all channels at once.
- A software load command has the same effect as the pin.
- A writethrough command writes the staging and live registers of the selected channels from the frame itself.

A ready output goes low once a complete frame has been shifted in, and it returns high when the select is released.

All pins are brought into one system clock domain through two-flop synchronisers. The serial clock is then edge-detected in that domain. The system clock must therefore run several times faster than the serial clock. A frame counts only if exactly 24 bits arrive between the select going low and the select going high. Any other length is thrown away, and no register changes.

Top module: `qdac_serial_front`

## Requirements
- R1: After a synchronous active-low reset, every output register is zero and `ready_out` is high.
- R2: With `sel_n_in` low, one data bit is captured on each rising edge of `sclk_in`, most significant bit first. Frame bits 23:16 form the command and bits 15:0 form the value. Every pin passes through a two-flop synchroniser, so a pin change takes effect at the third rising system-clock edge after it. A frame is committed on that edge after `sel_n_in` rises, and only if exactly 24 bits were captured.
- R3: A frame with fewer than 24 or more than 24 captured bits is discarded without changing any register.
- R4: Command bits 23:20 = 0x1 (write) load the value into the staging register of each selected channel. The live outputs stay unchanged.
- R5: While the synchronised `load_n_in` is low, every live register takes the value of its staging register on each clock.
- R6: Command bits 23:20 = 0x3 (software load) copy all four staging registers into the live registers together, whatever the mask and value are.
- R7: Command bits 23:20 = 0x2 (writethrough) load the value into both the staging and the live register of each selected channel. On those channels this takes priority over a hardware load in the same cycle. Unselected channels are untouched.
- R8: Command bits 19:16 are a channel mask, with bit 16 selecting channel 0 and bit 19 selecting channel 3. One frame can update any subset of channels. Channel c drives `dac_word_out[16c+15:16c]`.
- R9: A frame whose command bits 23:20 are none of 0x1, 0x2 or 0x3 changes no register.
- R10: `ready_out` goes low once the 24th bit has been captured. It returns high on the edge at which the synchronised select is seen high.
- R11: A frame is accepted only after the select has been seen high for at least one system clock since reset. A high pulse on `sel_n_in` that no clock edge samples does not end the frame. The bits of the two frames then run together and are discarded as over-length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sclk_in | input | 1 | Serial clock from the host |
| sdi_in | input | 1 | Serial data from the host, MSB first |
| sel_n_in | input | 1 | Frame select, active low |
| load_n_in | input | 1 | Hardware load of all channels, active low |
| ready_out | output | 1 | High when idle or mid-frame, low once 24 bits are held |
| dac_word_out | output | 64 | Live registers, channel c in bits 16c+15:16c |

## Verification
Frames are sent with single-channel, multi-channel and empty masks, and with every command class. These patterns separate the staging path from the live path, and they tell a writethrough apart from a plain write followed by a load. Frames of 23 and 25 bits, and two frames merged by a select pulse that no clock samples, check that the commit depends on the exact bit count and not merely on reaching 24. A hardware load pulse and a software load command run over the same staged contents, which shows that the two paths are equivalent. Unknown command classes are followed by a software load, which brings out at the ports the staging registers they could have touched.

// File: rtl/qdac_pkg.sv
`timescale 1ns/1ps
// Shared constants for the quad serial front end: command field layout
// and command class codes. No state, no logic.
package qdac_pkg;
    localparam int CMD_W   = 8;      // command byte width
    localparam int CLASS_W = 4;      // command class field width (top of command)
    localparam logic [CLASS_W-1:0] CLS_WRITE = 4'h1;  // staging only
    localparam logic [CLASS_W-1:0] CLS_THRU  = 4'h2;  // staging and live
    localparam logic [CLASS_W-1:0] CLS_LOAD  = 4'h3;  // copy all staging to live
endpackage

// File: rtl/qdac_sync.sv
`timescale 1ns/1ps
// Two-flop synchroniser, one pair of flops per bit.
// Assumes each input bit is an independent asynchronous level; resets to zero.
module qdac_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Two-stage resampling of the asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/qdac_frame_rx.sv
`timescale 1ns/1ps
// Serial frame receiver. Shifts in one bit per detected rising serial-clock
// edge while select is low, MSB first. It issues a one-cycle commit when select
// is seen high after exactly FRAME_W bits. Any other count is dropped.
// Assumes all inputs are already synchronous to clk.
module qdac_frame_rx #(
    parameter int FRAME_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_s,
    input  logic               sdi_s,
    input  logic               sel_n_s,
    output logic [FRAME_W-1:0] frame_q,
    output logic               commit,
    output logic               ready
);
    localparam int CW = $clog2(FRAME_W + 2);
    localparam logic [CW-1:0] FULL = CW'(FRAME_W);

    logic          sclk_d;
    logic          seen_idle;
    logic [CW-1:0] bit_cnt;
    logic          sclk_rise;

    assign sclk_rise = sclk_s & ~sclk_d;

    // Edge history, idle tracking, bit counting and shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d    <= 1'b0;
            seen_idle <= 1'b0;
            bit_cnt   <= '0;
            frame_q   <= '0;
        end else begin
            sclk_d <= sclk_s;
            if (sel_n_s) begin
                seen_idle <= 1'b1;
                bit_cnt   <= '0;
            end else if (seen_idle && sclk_rise && bit_cnt <= FULL) begin
                bit_cnt <= bit_cnt + 1'b1;       // saturates at FULL+1 (over-length)
                if (bit_cnt < FULL) begin
                    frame_q <= {frame_q[FRAME_W-2:0], sdi_s};
                end
            end
        end
    end

    // Commit on release of select only with an exact-length frame.
    assign commit = sel_n_s && (bit_cnt == FULL);
    assign ready  = (bit_cnt < FULL);
endmodule

// File: rtl/qdac_chan_bank.sv
`timescale 1ns/1ps
// Per-channel staging and live registers with three update paths: hardware
// load (level, all channels), software load command, and writethrough.
// Assumes commit is a one-cycle pulse and frame is stable while it is high.
module qdac_chan_bank
    import qdac_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CMD_W+DW-1:0]     frame,
    input  logic                    commit,
    input  logic                    load_n_s,
    output logic [NCH*DW-1:0]       dac_word_out
);
    localparam int FW = CMD_W + DW;

    logic [CLASS_W-1:0] cls;
    logic [NCH-1:0]     mask;
    logic [DW-1:0]      value;
    logic               do_write, do_thru, do_load_all;

    // Split the frame into class, mask and value and decode the class.
    always_comb begin
        cls         = frame[FW-1 -: CLASS_W];
        mask        = frame[DW +: NCH];
        value       = frame[DW-1:0];
        do_write    = commit && (cls == CLS_WRITE);
        do_thru     = commit && (cls == CLS_THRU);
        do_load_all = commit && (cls == CLS_LOAD);
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [DW-1:0] stage_q;
        logic [DW-1:0] live_q;

        // Staging register: loaded by write or writethrough on a selected channel.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_q <= '0;
            end else if ((do_write || do_thru) && mask[c]) begin
                stage_q <= value;
            end
        end

        // Live register: writethrough wins, else any load copies staging.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                live_q <= '0;
            end else if (do_thru && mask[c]) begin
                live_q <= value;
            end else if (!load_n_s || do_load_all) begin
                live_q <= stage_q;
            end
        end

        assign dac_word_out[c*DW +: DW] = live_q;
    end
endmodule

// File: rtl/qdac_serial_front.sv
`timescale 1ns/1ps
// Top of the quad double-buffered serial front end. Synchronises the four
// host pins, receives 24-bit frames and updates the channel bank.
// Assumes clk runs several times faster than the serial clock.
module qdac_serial_front
    import qdac_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_in,
    input  logic              sdi_in,
    input  logic              sel_n_in,
    input  logic              load_n_in,
    output logic              ready_out,
    output logic [NCH*DW-1:0] dac_word_out
);
    localparam int FW = CMD_W + DW;

    logic              sclk_s, sdi_s, sel_n_s, load_n_s;
    logic [FW-1:0]     frame_q;
    logic              commit;

    qdac_sync #(.W(4)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({load_n_in, sel_n_in, sdi_in, sclk_in}),
        .q     ({load_n_s, sel_n_s, sdi_s, sclk_s})
    );

    qdac_frame_rx #(.FRAME_W(FW)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_s  (sclk_s),
        .sdi_s   (sdi_s),
        .sel_n_s (sel_n_s),
        .frame_q (frame_q),
        .commit  (commit),
        .ready   (ready_out)
    );

    qdac_chan_bank #(.NCH(NCH), .DW(DW)) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame        (frame_q),
        .commit       (commit),
        .load_n_s     (load_n_s),
        .dac_word_out (dac_word_out)
    );
endmodule

// File: rtl/qdac_checker.sv
`timescale 1ns/1ps
// Property checker for qdac_serial_front, attached by bind. It observes the
// synchronised select and load, the receiver commit and frame, and the outputs.
module qdac_checker
    import qdac_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sel_n_s,
    input logic                 load_n_s,
    input logic                 commit,
    input logic [CMD_W+DW-1:0]  frame,
    input logic                 ready_out,
    input logic [NCH*DW-1:0]    dac_word_out
);
    localparam int FW = CMD_W + DW;

    logic [CLASS_W-1:0] cls;
    assign cls = frame[FW-1 -: CLASS_W];

    // R1: reset clears the outputs and raises ready.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (dac_word_out == '0 && ready_out));

    // R3: no commit is issued while ready is high (fewer than 24 bits held).
    p_short_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n_s && ready_out) |-> !commit);

    // R4: without a live-path command or a load, the outputs hold.
    p_live_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n_s && !(commit && (cls == CLS_THRU || cls == CLS_LOAD)))
        |=> $stable(dac_word_out));

    // R10: ready falls only while select is low, and rises only after select is seen high.
    p_ready_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready_out) |-> !sel_n_s);
    p_ready_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_out) |-> $past(sel_n_s));

    // R7: writethrough on a selected channel lands the value on that output next cycle.
    for (genvar c = 0; c < NCH; c++) begin : g_thru
        p_thru_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (commit && cls == CLS_THRU && frame[DW + c])
            |=> dac_word_out[c*DW +: DW] == $past(frame[DW-1:0]));
    end
endmodule

bind qdac_serial_front qdac_checker #(.NCH(NCH), .DW(DW)) u_qdac_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .sel_n_s      (sel_n_s),
    .load_n_s     (load_n_s),
    .commit       (commit),
    .frame        (frame_q),
    .ready_out    (ready_out),
    .dac_word_out (dac_word_out)
);

// File: tb/qdac_serial_front_bench.sv
`timescale 1ns/1ps
// Bench for qdac_serial_front. A behavioural reference model advances once
// per clock, at the falling edge, and is compared with the outputs on every clock.
module qdac_serial_front_bench;
    localparam int NCH = 4;
    localparam int DW  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, sdi = 1'b0, sel_n = 1'b1, load_n = 1'b1;
    logic ready;
    logic [NCH*DW-1:0] dac;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;   // 200 MHz

    qdac_serial_front #(.NCH(NCH), .DW(DW)) u_qdac_serial_front (
        .clk(clk), .rst_n(rst_n), .sclk_in(sclk), .sdi_in(sdi),
        .sel_n_in(sel_n), .load_n_in(load_n),
        .ready_out(ready), .dac_word_out(dac)
    );

    // ---------------- reference model ----------------
    // Pin history: index 0 is the value as seen three edges after the pin change.
    bit        h_sclk[2], h_sdi[2], h_sel[2], h_ld[2];
    bit        m_prev_sclk, m_seen, m_valid;
    int        m_cnt;
    bit [23:0] m_word;
    bit [15:0] m_stage[NCH], m_live[NCH];

    task automatic model_step();
        bit        rise, cm;
        bit [3:0]  cls, msk;
        bit [15:0] val;
        bit [15:0] ns[NCH], nl[NCH];
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin m_stage[c] = 0; m_live[c] = 0; end
            h_sclk = '{0, 0}; h_sdi = '{0, 0}; h_sel = '{0, 0}; h_ld = '{0, 0};
            m_prev_sclk = 0; m_seen = 0; m_cnt = 0; m_word = 0; m_valid = 1;
            return;
        end
        rise = h_sclk[0] && !m_prev_sclk;
        cm   = h_sel[0] && (m_cnt == 24);
        cls  = m_word[23:20]; msk = m_word[19:16]; val = m_word[15:0];
        for (int c = 0; c < NCH; c++) begin
            ns[c] = m_stage[c]; nl[c] = m_live[c];
            if (!h_ld[0] || (cm && cls == 4'h3)) nl[c] = m_stage[c];
            if (cm && msk[c] && (cls == 4'h1 || cls == 4'h2)) ns[c] = val;
            if (cm && msk[c] && cls == 4'h2) nl[c] = val;
        end
        for (int c = 0; c < NCH; c++) begin m_stage[c] = ns[c]; m_live[c] = nl[c]; end
        if (h_sel[0]) begin
            m_seen = 1; m_cnt = 0;
        end else if (m_seen && rise && m_cnt <= 24) begin
            if (m_cnt < 24) m_word = {m_word[22:0], h_sdi[0]};
            m_cnt++;
        end
        m_prev_sclk = h_sclk[0];
        h_sclk = '{h_sclk[1], sclk}; h_sdi = '{h_sdi[1], sdi};
        h_sel  = '{h_sel[1], sel_n}; h_ld  = '{h_ld[1], load_n};
    endtask

    // Per-clock comparison against the model, then advance it.
    always @(negedge clk) begin
        if (m_valid && !done) begin
            for (int c = 0; c < NCH; c++) begin
                checks++;
                if (dac[c*DW +: DW] !== m_live[c]) begin
                    fails++;
                    $display("FAIL %s ch%0d live: actual=%h expected=%h",
                             cur_req, c, dac[c*DW +: DW], m_live[c]);
                end
            end
            checks++;
            if (ready !== (m_cnt < 24)) begin
                fails++;
                $display("FAIL %s ready: actual=%b expected=%b", cur_req, ready, (m_cnt < 24));
            end
        end
        model_step();
    end

    // ---------------- helpers ----------------
    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check_val(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic shift_bits(input logic [47:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            sdi = v[i]; tick(2); sclk = 1'b1; tick(2); sclk = 1'b0;
        end
        tick(3);
    endtask

    task automatic send_bits(input logic [47:0] v, input int n, input bit chk_rdy);
        sel_n = 1'b0; tick(2);
        shift_bits(v, n);
        if (chk_rdy) check_val("R10 ready low after 24 bits", 32'(ready), 32'd0);
        sel_n = 1'b1; tick(5);
        if (chk_rdy) check_val("R10 ready high after release", 32'(ready), 32'd1);
    endtask

    task automatic frame(input logic [7:0] cmd, input logic [15:0] val);
        send_bits({24'd0, cmd, val}, 24, 1'b0);
    endtask

    function automatic logic [15:0] ch(input int c);
        return dac[c*DW +: DW];
    endfunction

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R2 watchdog: actual=running expected=finished");
            finish_run();
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        tick(4);
        rst_n = 1'b1;
        tick(1);
        cur_req = "R1";
        check_val("R1 outputs zero after reset", 32'(dac == '0), 32'd1);
        check_val("R1 ready high after reset", 32'(ready), 32'd1);
        tick(3);

        cur_req = "R4";
        frame(8'h11, 16'h1234);
        check_val("R4 write leaves ch0 live", 32'(ch(0)), 32'h0);

        cur_req = "R6";
        frame(8'h30, 16'hFFFF);
        check_val("R6 soft load ch0", 32'(ch(0)), 32'h1234);
        check_val("R2 R6 soft load ch1 staging zero", 32'(ch(1)), 32'h0);

        cur_req = "R8";
        frame(8'h1E, 16'hBEEF);
        check_val("R8 multi-mask write leaves ch1 live", 32'(ch(1)), 32'h0);

        cur_req = "R5";
        load_n = 1'b0; tick(2); load_n = 1'b1; tick(5);
        check_val("R5 hw load ch1", 32'(ch(1)), 32'hBEEF);
        check_val("R5 hw load ch3", 32'(ch(3)), 32'hBEEF);
        check_val("R5 hw load ch0", 32'(ch(0)), 32'h1234);

        cur_req = "R7";
        frame(8'h25, 16'hA5A5);
        check_val("R7 writethrough ch0", 32'(ch(0)), 32'hA5A5);
        check_val("R7 writethrough ch2", 32'(ch(2)), 32'hA5A5);
        check_val("R7 unselected ch1", 32'(ch(1)), 32'hBEEF);

        cur_req = "R3";
        send_bits({24'd0, 8'h2F, 16'h0001} >> 1, 23, 1'b0);
        send_bits({23'd0, 8'h2F, 16'h0001, 1'b1}, 25, 1'b0);
        check_val("R3 short and long frames dropped ch3", 32'(ch(3)), 32'hBEEF);

        cur_req = "R9";
        frame(8'h5F, 16'h7777);
        frame(8'h0F, 16'h7777);
        frame(8'h30, 16'h0000);
        check_val("R9 unknown class ch0 staging", 32'(ch(0)), 32'hA5A5);
        check_val("R9 unknown class ch1 staging", 32'(ch(1)), 32'hBEEF);

        cur_req = "R10";
        send_bits({24'd0, 8'h28, 16'h0F0F}, 24, 1'b1);
        check_val("R10 frame committed ch3", 32'(ch(3)), 32'h0F0F);

        cur_req = "R11";
        sel_n = 1'b0; tick(2);
        shift_bits({24'd0, 8'h21, 16'h5555}, 24);
        @(posedge clk); #3 sel_n = 1'b1; #1 sel_n = 1'b0;
        tick(2);
        shift_bits({24'd0, 8'h22, 16'h6666}, 24);
        sel_n = 1'b1; tick(5);
        check_val("R11 merged frames dropped ch0", 32'(ch(0)), 32'hA5A5);
        check_val("R11 merged frames dropped ch1", 32'(ch(1)), 32'hBEEF);

        cur_req = "R2";
        for (int k = 0; k < 16; k++) begin
            logic [3:0] cls;
            case (k % 4)
                0: cls = 4'h1;
                1: cls = 4'h2;
                2: cls = 4'h3;
                default: cls = 4'h7;
            endcase
            frame({cls, 4'((k * 7 + 3) % 16)}, 16'(k * 16'h1357) ^ 16'hA0A0);
            if (k == 5) begin load_n = 1'b0; tick(3); load_n = 1'b1; tick(4); end
        end
        tick(4);
        finish_run();
    end
endmodule